// File: doc/BRIEF.md
# Synchronous Serial Controller with Queued Words

This block is a register-mapped serial controller that drives one external device over a four-wire clocked serial link. Software programs the word width, the clock polarity and phase, and a two-stage clock divider, then pushes words into a transmit queue by writing the data register. The block turns each queued word into one frame. It pulls the select line low, toggles the serial clock, and shifts the word out most significant bit first. At the same time it shifts a reply word in from the input line, or from its own output line when internal loopback is selected.

Received words land in a receive queue that software drains by reading the same data register. A five-bit status word reports whether each queue is empty or full and whether a frame is in progress. Frames begin only while the enable bit is set. Software can clear that bit in the middle of a frame: the frame still completes, and then the block stays idle.

The bus uses byte offsets 0x00 (control A), 0x04 (control B), 0x08 (data), 0x0C (status) and 0x10 (prescale). Address bits 1:0 are ignored. Register writes take effect on the clock edge where the write strobe is sampled. Reads return data combinationally, and a data read pops the receive queue on that same edge.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the status word reads 0x03 (both queues empty), select is high, the serial clock and data out are low, and control A and prescale read 0.
- R2: Control A reads back all 16 bits and control B reads back its 4 bits. Prescale bit 0 always reads 0.
- R3: The transmit queue holds 8 words. A data write while it is full is dropped, and status bit 1 (transmit not full) reads 0 while 8 words wait.
- R4: A frame starts only while control B bit 1 (enable) is 1. Clearing enable during a frame lets that frame complete, and no further frame starts.
- R5: The word width is control A bits 3:0 plus one for field values 3..15. Values 0..2 give 4 bits. Words are sent and received most significant bit first, right-aligned in the data register.
- R6: With D = max(1, P/2), where P is the prescale value with bit 0 cleared, and S = control A bits 15:8, each serial clock half-period lasts D*(S+1) clocks. Select stays low for (2W+1) half-periods per W-bit frame.
- R7: Control A bit 6 sets the idle serial clock level. Control A bit 7 selects sampling on the leading edge (0) or the trailing edge (1), and data out changes on the other edge.
- R8: Select is low for each frame and returns high for at least one clock between consecutive frames.
- R9: With control B bit 0 set, the receive path takes data out and the input line has no effect.
- R10: The receive queue holds 8 words and a data read pops the oldest. A word completing while the queue is full is discarded. Status bit 3 is receive full and bit 2 is receive not empty.
- R11: Status bit 4 reads 1 while a frame is in progress.
- R12: Control A bits 5:4 and control B bits 3:2 are stored but do not change frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue on data reads) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low device select |
| miso | input | 1 | Serial data in |

## Verification
The hardest cases to reach are a cleared enable that lands inside a running frame and a word that completes while the receive queue is already full. The first needs a slow divider so the bus write arrives mid-frame. The second needs the transmit queue filled while the block is disabled, then released and left undrained, followed by one more word. A bench device model replies on the opposite edge for all four clock modes, which shows that the sampling and shifting edges are correct. Loopback runs sweep every word width while the input line carries the inverse of the sent word.

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_N = (AW+1)'(DEPTH);

  logic [15:0] cr0;
  logic [3:0]  cr1;
  logic [7:0]  cps;
  logic [15:0] txm [DEPTH];
  logic [15:0] rxm [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic        busy, lvl;
  logic [5:0]  hcnt;
  logic [6:0]  pre_cnt;
  logic [7:0]  scr_cnt;
  logic [15:0] sr, rsr;

  wire [2:0] sel = bus_addr[4:2];
  wire unused_addr = &{1'b0, bus_addr[1:0]};

  wire [AW:0] tx_cnt   = tx_wp - tx_rp;
  wire [AW:0] rx_cnt   = rx_wp - rx_rp;
  wire        tx_empty = tx_cnt == '0;
  wire        tx_full  = tx_cnt == FULL_N;
  wire        rx_empty = rx_cnt == '0;
  wire        rx_full  = rx_cnt == FULL_N;

  wire [3:0]  wm1  = (cr0[3:0] < 4'd3) ? 4'd3 : cr0[3:0];
  wire [3:0]  lsh  = 4'd15 - wm1;
  wire [15:0] mask = 16'hFFFF >> lsh;
  wire [5:0]  last = {1'b0, wm1, 1'b0} + 6'd2;
  wire        cpha = cr0[7];

  wire [6:0] lim     = cps[7:1];
  wire       pre_hit = (pre_cnt + 7'd1) >= lim;
  wire       tick    = busy && pre_hit && (scr_cnt == cr0[15:8]);
  wire       fin     = tick && (hcnt == last);
  wire       edg     = tick && !fin;
  wire       lead    = !lvl;
  wire       samp    = edg && (lead ^ cpha);
  wire       shft    = edg && !(lead ^ cpha) && !(cpha && hcnt == 6'd0);
  wire       din     = cr1[0] ? mosi : miso;

  wire start   = !busy && cr1[1] && !tx_empty;
  wire tx_push = bus_wr && sel == 3'd2 && !tx_full;
  wire rx_push = fin && !rx_full;
  wire rx_pop  = bus_rd && sel == 3'd2 && !rx_empty;

  assign sclk = cr0[6] ^ lvl;
  assign mosi = sr[15];
  assign cs_n = !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cr0 <= '0;
      cr1 <= '0;
      cps <= '0;
    end else if (bus_wr) begin
      if (sel == 3'd0) cr0 <= bus_wdata;
      if (sel == 3'd1) cr1 <= bus_wdata[3:0];
      if (sel == 3'd4) cps <= {bus_wdata[7:1], 1'b0};
    end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp[AW-1:0]] <= bus_wdata;
    if (rx_push) rxm[rx_wp[AW-1:0]] <= rsr & mask;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; lvl <= 1'b0; hcnt <= '0;
      pre_cnt <= '0; scr_cnt <= '0; sr <= '0; rsr <= '0;
    end else if (start) begin
      busy <= 1'b1; lvl <= 1'b0; hcnt <= '0;
      pre_cnt <= '0; scr_cnt <= '0; rsr <= '0;
      sr <= txm[tx_rp[AW-1:0]] << lsh;
    end else if (busy) begin
      pre_cnt <= pre_hit ? 7'd0 : pre_cnt + 7'd1;
      if (pre_hit) scr_cnt <= (scr_cnt == cr0[15:8]) ? 8'd0 : scr_cnt + 8'd1;
      if (fin) busy <= 1'b0;
      if (edg) begin
        lvl  <= ~lvl;
        hcnt <= hcnt + 6'd1;
      end
      if (samp) rsr <= {rsr[14:0], din};
      if (shft) sr  <= sr << 1;
    end

  always_comb
    case (sel)
      3'd0:    bus_rdata = cr0;
      3'd1:    bus_rdata = {12'd0, cr1};
      3'd2:    bus_rdata = rx_empty ? 16'd0 : rxm[rx_rp[AW-1:0]];
      3'd3:    bus_rdata = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
      3'd4:    bus_rdata = {8'd0, cps};
      default: bus_rdata = 16'd0;
    endcase

  a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == 3'd2 && tx_full && !start) |=> $stable(tx_cnt));

  a_r10_full_rx_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rx_full && !rx_pop) |=> rx_full);

  a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(cr1[1]));

  a_r6_sclk_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !(bus_wr && sel == 3'd0)) |=> $stable(sclk));

  a_r8_queue_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_N) && (rx_cnt <= FULL_N));
endmodule

// File: tb/sim_spi_ctrl.sv
module sim_spi_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sclk, mosi, cs_n;
  logic miso = 1'b0;

  int checks = 0, fails = 0;

  spi_ctrl #(.DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  always #5 clk = ~clk;

  logic [15:0] s_reply = '0, s_cap = '0;
  int s_w = 8, s_bit = 0;
  logic s_cpha = 1'b0, s_spo = 1'b0, s_act = 1'b0, s_prev = 1'b0, prev_cs = 1'b1;
  int lowcnt = 0, last_len = 0, nfalls = 0;

  always @(negedge clk) begin
    if (s_act && sclk !== s_prev) begin
      if ((sclk != s_spo) == !s_cpha) s_cap = {s_cap[14:0], mosi};
      else if (s_bit >= 0) begin miso = s_reply[s_bit]; s_bit--; end
      s_prev = sclk;
    end
    if (cs_n) begin
      s_act = 1'b0; s_prev = sclk;
    end else if (!s_act) begin
      s_act = 1'b1; s_prev = sclk; s_cap = '0;
      if (!s_cpha) begin miso = s_reply[s_w-1]; s_bit = s_w - 2; end
      else s_bit = s_w - 1;
    end
    if (cs_n && !prev_cs) begin last_len = lowcnt; lowcnt = 0; end
    if (!cs_n) begin
      if (prev_cs) begin nfalls++; lowcnt = 0; end
      lowcnt++;
    end
    prev_cs = cs_n;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do brd(5'h0C, s); while (!(s[4] == 1'b0 && s[0] == 1'b1));
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, word;
    int cps_l[6] = '{0, 2, 3, 4, 10, 254};
    int wl[5] = '{4, 7, 8, 12, 16};
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    brd(5'h0C, v); chk("R1 status", v, 16'h03);
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 mosi", mosi, 0);
    brd(5'h00, v); chk("R1 cr0", v, 0);
    brd(5'h10, v); chk("R1 cps", v, 0);

    bwr(5'h00, 16'hA5C7); brd(5'h00, v); chk("R2 cr0", v, 16'hA5C7);
    bwr(5'h04, 16'hFFFF); brd(5'h04, v); chk("R2 cr1", v, 16'h000F);
    bwr(5'h04, 16'h0000);
    bwr(5'h10, 16'h0037); brd(5'h10, v); chk("R2 cps bit0", v, 16'h0036);

    // loopback sweep, all widths and modes, input line inverted (R5 R7 R9 R6)
    bwr(5'h10, 16'd2);
    bwr(5'h04, 16'h0003);
    for (int m = 0; m < 4; m++)
      for (int d = 3; d < 16; d++) begin
        word = 16'(d * 16'h1357 + m * 16'h2468 + 16'h0A5B);
        s_w = d + 1; s_cpha = m[1]; s_spo = m[0]; s_reply = ~word;
        bwr(5'h00, {8'd0, m[1], m[0], 2'b00, 4'(d)});
        bwr(5'h08, word);
        wait_idle();
        brd(5'h08, v);
        chk("R9 loopback data", v, word & (16'hFFFF >> (15 - d)));
        chk("R6 frame length", last_len, 2 * (d + 1) + 1);
        chk("R7 idle level", sclk, m[0]);
      end

    // size field below 3 acts as 4 bits (R5)
    bwr(5'h00, 16'h0001); bwr(5'h08, 16'hFFF9); wait_idle();
    brd(5'h08, v); chk("R5 small size data", v, 16'h0009);
    chk("R5 small size length", last_len, 9);

    // divider sweep (R6)
    for (int i = 0; i < 6; i++)
      for (int s = 0; s < 3; s += 2) begin
        int h;
        h = ((cps_l[i] >> 1) == 0 ? 1 : (cps_l[i] >> 1)) * (s + 1);
        bwr(5'h10, 16'(cps_l[i]));
        bwr(5'h00, 16'(s << 8) | 16'h0007);
        bwr(5'h08, 16'h00C3); wait_idle();
        brd(5'h08, v); chk("R6 data", v, 16'h00C3);
        chk("R6 divided length", last_len, 17 * h);
      end

    // external device, all modes, stored-only bits set (R5 R7 R12)
    bwr(5'h10, 16'd4);
    bwr(5'h04, 16'h000E);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 5; k++) begin
        word = 16'(16'hB38D + k * 16'h0F1 + m * 16'h33);
        s_w = wl[k]; s_cpha = m[1]; s_spo = m[0];
        s_reply = 16'(16'h6C29 ^ (k * 16'h1111) ^ m);
        bwr(5'h00, {8'd1, m[1], m[0], 2'b10, 4'(wl[k] - 1)});
        bwr(5'h08, word); wait_idle();
        brd(5'h08, v);
        chk("R7 received reply", v, s_reply & (16'hFFFF >> (16 - wl[k])));
        chk("R5 sent msb first", s_cap & (16'hFFFF >> (16 - wl[k])),
            word & (16'hFFFF >> (16 - wl[k])));
        chk("R12 length unchanged", last_len, (2 * wl[k] + 1) * 4);
      end

    // queue limits (R3 R8 R10)
    bwr(5'h10, 16'd2); bwr(5'h00, 16'h0007); bwr(5'h04, 16'h0001);
    for (int i = 0; i < 9; i++) bwr(5'h08, 16'(8'h30 + i * 7));
    brd(5'h0C, v); chk("R3 tx full status", v, 16'h00);
    base = nfalls;
    bwr(5'h04, 16'h0003); wait_idle();
    brd(5'h0C, v); chk("R10 rx full status", v, 16'h0F);
    chk("R8 separate frames", nfalls - base, 8);
    bwr(5'h08, 16'h00EE); wait_idle();
    for (int i = 0; i < 8; i++) begin
      brd(5'h08, v); chk("R3 R10 queue order", v, 8'h30 + i * 7);
    end
    brd(5'h0C, v); chk("R10 overflow discarded", v, 16'h03);

    // enable cleared mid-frame (R4 R11)
    bwr(5'h04, 16'h0001); bwr(5'h10, 16'd20);
    bwr(5'h08, 16'h0011); bwr(5'h08, 16'h0022); bwr(5'h08, 16'h0033);
    repeat (50) @(negedge clk);
    chk("R4 no start disabled", cs_n, 1);
    brd(5'h0C, v); chk("R4 held words", v, 16'h02);
    base = nfalls;
    bwr(5'h04, 16'h0003);
    while (cs_n) @(negedge clk);
    brd(5'h0C, v); chk("R11 busy bit", v[4], 1);
    bwr(5'h04, 16'h0001);
    repeat (400) @(negedge clk);
    chk("R4 one frame", nfalls - base, 1);
    brd(5'h0C, v); chk("R4 status after stop", v, 16'h06);
    brd(5'h08, v); chk("R4 finished word", v, 16'h0011);
    bwr(5'h04, 16'h0003); wait_idle();
    brd(5'h08, v); chk("R4 resumed word", v, 16'h0022);
    brd(5'h08, v); chk("R4 resumed word", v, 16'h0033);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule